// File: doc/BRIEF.md
# I2C SCL Divider with Standard and Fast Timing

This block turns the peripheral clock into the SCL waveform and the timing strobes an I2C master's byte engine needs. A 12-bit divider value is assembled from two configuration bytes. The low seven bits come from the clock control byte, and the upper five come from the extension byte. The top bit of the clock control byte chooses between standard and fast timing. Each mode converts the divider into an SCL period with its own fixed offset. Standard mode splits the period roughly evenly between low and high. Fast mode spends about twice as long low as high.

While enabled, the block drives SCL low for the low phase and then releases it. The high phase is counted only in cycles where the line is actually seen high, so a slave that holds SCL low stretches the period. Strobes mark four points: the start of each low phase, the first counted high cycle, a mid-high sample point, and a data-change point inside the low phase. The data-change point is set by a 3-bit input-clock band field. The divider, mode and band are captured at the start of each period, so writes made during a transfer apply from the next period. A divider below 2 is refused: SCL stays released and a configuration error is flagged.

Top module: `scl_timebase`

## Requirements
- R1: While reset is asserted, and in the cycle after `run` is sampled low, `scl_o` is 1 and `low_tick`, `high_tick`, `sample_tick` and `hold_tick` are 0.
- R2: The divider CC is `{ext_reg[4:0], ctl_reg[6:0]}`. `ctl_reg[7]` = 1 selects fast mode and 0 selects standard mode. `ext_reg[7:5]` has no effect.
- R3: In standard mode each period has CC+3 low cycles followed by CC+2 high cycles, for 2*CC+5 cycles in total when the line is not stretched.
- R4: In fast mode each period has 2*CC+4 low cycles followed by CC+2 high cycles, for 3*CC+6 cycles in total when the line is not stretched.
- R5: `cfg_err` is 1 exactly when the live CC is 0 or 1. A period never starts with such a value: `scl_o` stays 1 and no strobe fires.
- R6: `low_tick` pulses in the first low cycle of every period. `high_tick` pulses once per period, in the first high cycle in which `scl_in` is 1.
- R7: `sample_tick` pulses once per period, at counted high cycle index floor((CC+2)/2), with indices counted from 0.
- R8: `hold_tick` pulses once per period at low-phase cycle index min(band+1, L-1). Here L is the low length and band is `band_cfg` as captured at the period start.
- R9: While the block is in its high phase and `scl_in` is 0, the high count holds. A stretch of k cycles lengthens the high phase by exactly k cycles.
- R10: CC, mode and band are captured only when a period starts. A change made mid-period applies from the next period. If the new CC is invalid, the block goes idle after the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables SCL generation; when low, SCL is released and the count is cleared |
| ctl_reg | input | 8 | Bit 7 selects the mode; bits 6:0 are divider bits 6:0 |
| ext_reg | input | 8 | Bits 4:0 are divider bits 11:7 |
| band_cfg | input | 3 | Input clock band code; sets the data-change point |
| scl_in | input | 1 | SCL as seen on the wired bus |
| scl_o | output | 1 | 0 drives SCL low, 1 releases it |
| low_tick | output | 1 | First cycle of the low phase |
| high_tick | output | 1 | First counted high cycle |
| sample_tick | output | 1 | Mid-high sample point |
| hold_tick | output | 1 | Data-change point in the low phase |
| cfg_err | output | 1 | Live divider value is below 2 |

## Verification
The hardest situations to reach are a configuration write that lands inside a running period and a slave stretch that begins exactly as SCL is released. The bench watches `scl_o` cycle by cycle and writes the new divider as soon as the high phase is seen. It then measures both the period in progress and the next one, including a switch to an invalid divider that must leave the line idle. For stretching, the bench models the wired bus as `scl_o` ANDed with a slave hold. It releases the hold after a chosen number of high samples and checks both the lengthened high phase and the new position of the first-high strobe.

// File: rtl/scl_timebase.sv
module scl_timebase #(
  parameter int CC_LO_W = 7,
  parameter int CC_HI_W = 5,
  parameter int REG_W   = 8,
  parameter int BAND_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [REG_W-1:0]  ctl_reg,
  input  logic [REG_W-1:0]  ext_reg,
  input  logic [BAND_W-1:0] band_cfg,
  input  logic              scl_in,
  output logic              scl_o,
  output logic              low_tick,
  output logic              high_tick,
  output logic              sample_tick,
  output logic              hold_tick,
  output logic              cfg_err
);
  localparam int DIV_W = CC_LO_W + CC_HI_W;
  localparam int CNT_W = DIV_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [DIV_W-1:0]   div_q;
  logic               fast_q;
  logic [BAND_W-1:0]  band_q;

  wire [DIV_W-1:0] div_live  = {ext_reg[CC_HI_W-1:0], ctl_reg[CC_LO_W-1:0]};
  wire             fast_live = ctl_reg[CC_LO_W];

  wire [CNT_W-1:0] div_w     = CNT_W'(div_q);
  wire [CNT_W-1:0] lo_last   = fast_q ? (div_w << 1) + CNT_W'(3) : div_w + CNT_W'(2);
  wire [CNT_W-1:0] hi_last   = div_w + CNT_W'(1);
  wire [CNT_W-1:0] hold_want = CNT_W'(band_q) + CNT_W'(1);
  wire [CNT_W-1:0] hold_idx  = (hold_want <= lo_last) ? hold_want : lo_last;

  wire period_end = (phase == ST_HIGH) && scl_in && (cnt == hi_last);
  wire start      = run && !cfg_err && ((phase == ST_IDLE) || period_end);

  assign cfg_err     = div_live < DIV_W'(2);
  assign scl_o       = (phase != ST_LOW);
  assign low_tick    = (phase == ST_LOW) && (cnt == '0);
  assign hold_tick   = (phase == ST_LOW) && (cnt == hold_idx);
  assign high_tick   = (phase == ST_HIGH) && scl_in && (cnt == '0);
  assign sample_tick = (phase == ST_HIGH) && scl_in && (cnt == ((div_w + CNT_W'(2)) >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      div_q  <= '0;
      fast_q <= 1'b0;
      band_q <= '0;
    end else if (!run) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else if (start) begin
      phase  <= ST_LOW;
      cnt    <= '0;
      div_q  <= div_live;
      fast_q <= fast_live;
      band_q <= band_cfg;
    end else begin
      case (phase)
        ST_LOW:
          if (cnt == lo_last) begin
            phase <= ST_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        ST_HIGH:
          if (period_end) begin
            phase <= ST_IDLE;
            cnt   <= '0;
          end else if (scl_in) begin
            cnt <= cnt + CNT_W'(1);
          end
        default: cnt <= '0;
      endcase
    end
  end

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !low_tick && !hold_tick));

  assert_bad_div_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && phase == ST_IDLE) |=> scl_o);

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_tick, high_tick, sample_tick}));

  assert_sample_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> scl_in);

  assert_stretch_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == ST_HIGH && !scl_in) |=> (phase == ST_HIGH && $stable(cnt)));

  assert_cfg_frozen_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_LOW) |=> ($stable(div_q) && $stable(fast_q) && $stable(band_q)));
endmodule

// File: tb/test_scl_timebase.sv
module test_scl_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] ctl_reg = 8'h00;
  logic [7:0] ext_reg = 8'h00;
  logic [2:0] band_cfg = 3'd0;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       scl_o, low_tick, high_tick, sample_tick, hold_tick, cfg_err;
  int         checks = 0;
  int         fails = 0;
  int         stretch_k = 0;

  always #4 clk = ~clk;

  assign scl_in = scl_o & ~stretch;

  scl_timebase i_scl_timebase (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl_reg(ctl_reg), .ext_reg(ext_reg),
    .band_cfg(band_cfg), .scl_in(scl_in), .scl_o(scl_o), .low_tick(low_tick),
    .high_tick(high_tick), .sample_tick(sample_tick), .hold_tick(hold_tick),
    .cfg_err(cfg_err)
  );

  localparam int NV = 6;
  localparam int VF [NV] = '{0, 0, 1, 1, 0, 1};
  localparam int VD [NV] = '{2, 10, 2, 7, 200, 130};
  localparam int VB [NV] = '{7, 0, 3, 5, 2, 7};
  localparam int VL [NV] = '{5, 13, 8, 18, 203, 264};
  localparam int VH [NV] = '{4, 12, 4, 9, 202, 132};
  localparam int VHD[NV] = '{4, 1, 4, 6, 3, 8};
  localparam int VS [NV] = '{2, 6, 2, 4, 101, 66};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int fast, input int div, input int band);
    ctl_reg  = {fast[0], div[6:0]};
    ext_reg  = {3'b101, div[11:7]};
    band_cfg = band[2:0];
  endtask

  task automatic measure(output int lo, output int hi, output int hold_at,
                         output int htk_at, output int smp_at);
    int guard = 0;
    hold_at = -1; htk_at = -1; smp_at = -1;
    while (!low_tick && guard < 2000) begin @(negedge clk); guard++; end
    lo = 0;
    while (scl_o == 1'b0 && guard < 2000) begin
      if (hold_tick) hold_at = lo;
      lo++; @(negedge clk); guard++;
    end
    hi = 0;
    while (scl_o == 1'b1 && !low_tick && guard < 2000) begin
      if (stretch_k > 0 && hi == stretch_k) begin stretch = 1'b0; #1; end
      if (high_tick) htk_at = hi;
      if (sample_tick) smp_at = hi;
      hi++; @(negedge clk); guard++;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lo, hi, hd, ht, sm, cnt_low, cnt_tick;
    repeat (3) @(negedge clk);
    chk("R1 reset scl_o", scl_o, 1);
    chk("R1 reset strobes", low_tick | high_tick | sample_tick | hold_tick, 0);
    rst_n = 1'b1;
    set_cfg(0, 4, 0);
    repeat (5) @(negedge clk);
    chk("R1 run low scl_o", scl_o, 1);
    chk("R1 run low strobes", low_tick | high_tick | sample_tick | hold_tick, 0);

    // R2 R3 R4 R6 R7 R8: table of periods
    for (int i = 0; i < NV; i++) begin
      run = 1'b0;
      set_cfg(VF[i], VD[i], VB[i]);
      @(negedge clk);
      run = 1'b1;
      measure(lo, hi, hd, ht, sm);
      chk(VF[i] != 0 ? "R4 low length" : "R3 low length", lo, VL[i]);
      chk(VF[i] != 0 ? "R4 high length" : "R3 high length", hi, VH[i]);
      chk("R8 hold point", hd, VHD[i]);
      chk("R6 high strobe", ht, 0);
      chk("R7 sample point", sm, VS[i]);
    end

    // R2: upper extension bits matter, bits 7:5 do not
    run = 1'b0;
    ctl_reg = 8'h00; ext_reg = 8'h01; #1;
    chk("R2 ext bit gives 128", cfg_err, 0);
    ext_reg = 8'hE0; #1;
    chk("R2 ext bits 7:5 ignored", cfg_err, 1);

    // R5: invalid dividers
    set_cfg(0, 1, 0); #1;
    chk("R5 cfg_err div1", cfg_err, 1);
    set_cfg(1, 0, 0); #1;
    chk("R5 cfg_err div0", cfg_err, 1);
    set_cfg(0, 2, 0); #1;
    chk("R5 cfg_err div2", cfg_err, 0);
    set_cfg(0, 1, 0);
    @(negedge clk);
    run = 1'b1;
    cnt_low = 0; cnt_tick = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (!scl_o) cnt_low++;
      if (low_tick | high_tick | sample_tick | hold_tick) cnt_tick++;
    end
    chk("R5 idle with bad div", cnt_low, 0);
    chk("R5 no strobes with bad div", cnt_tick, 0);

    // R9: stretch by 6 cycles, std CC=4
    run = 1'b0;
    set_cfg(0, 4, 0);
    @(negedge clk);
    stretch = 1'b1; stretch_k = 6;
    run = 1'b1;
    measure(lo, hi, hd, ht, sm);
    stretch_k = 0; stretch = 1'b0;
    chk("R9 low unaffected", lo, 7);
    chk("R9 stretched high", hi, 12);
    chk("R9 first high strobe after release", ht, 6);
    chk("R9 sample after release", sm, 9);

    // R10: mid-period change to a valid divider
    run = 1'b0;
    set_cfg(0, 2, 0);
    @(negedge clk);
    run = 1'b1;
    while (!low_tick) @(negedge clk);
    while (!scl_o) @(negedge clk);
    set_cfg(0, 10, 0);
    hi = 0;
    while (scl_o && !low_tick && hi < 100) begin hi++; @(negedge clk); end
    chk("R10 current period keeps old high", hi, 4);
    measure(lo, hi, hd, ht, sm);
    chk("R10 next low uses new div", lo, 13);
    chk("R10 next high uses new div", hi, 12);

    // R10: mid-period change to an invalid divider
    while (!low_tick) @(negedge clk);
    set_cfg(0, 1, 0);
    cnt_low = 0;
    while (!scl_o) begin cnt_low++; @(negedge clk); end
    chk("R10 current low completes", cnt_low, 13);
    cnt_low = 0; cnt_tick = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (!scl_o) cnt_low++;
      if (low_tick) cnt_tick++;
    end
    chk("R10 idle after invalid change", cnt_low, 0);
    chk("R10 no new period", cnt_tick, 0);

    // R1: dropping run mid low phase
    set_cfg(1, 5, 0);
    @(negedge clk);
    while (!low_tick) @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R1 release after run drop", scl_o, 1);
    chk("R1 no strobe after run drop", low_tick | hold_tick, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule